// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus whose data line is held low by a target that lost its place in a byte, for instance after the host was reset in the middle of a transfer. It is run once at initialization. On a start request it takes over the open-drain clock and data lines. It clocks the bus one pulse at a time until the target lets go of the data line, and after each pulse it checks the data line. It then closes with a STOP condition, so that every compliant device resets its bus logic.

Timing comes from an external prescaler tick. Each clock low phase, each clock high phase and each part of the STOP lasts a set number of ticks. At most one byte plus the acknowledge slot is clocked out, which is nine pulses. If the data line is still low after that, or a target holds the clock low for too long, the block reports failure. The system must then use a stronger reset, such as a power cycle.

Top module: `bus_unjam`

## Requirements
- R1: During and directly after reset, both drive enables are 0 and busy, done and failed are all 0.
- R2: A drive enable of 1 pulls its line low and 0 releases it; the block never drives a line high, and while busy is 0 both enables are 0.
- R3: Each clock low phase (scl_oe_o = 1) lasts HALF_TICKS tick periods, apart from up to one tick period lost when the phase starts; each released high phase likewise lasts HALF_TICKS ticks once the clock line reads high.
- R4: One recovery run produces at most MAX_PULSES clock pulses (rising edges of scl_oe_o), 9 by default.
- R5: The data line is sampled at the end of each clock high phase, and pulsing stops at the first sample that reads high. A target that releases after N pulses (N ≤ 9) therefore receives exactly N pulses.
- R6: After the data line reads high, a STOP is formed with the clock released: sda_oe_o = 1 for HALF_TICKS ticks, then released for HALF_TICKS ticks. sda_oe_o is never 1 while scl_oe_o is 1.
- R7: If the data line already reads high when start is taken, no clock pulse is sent, the STOP follows at once, and the run succeeds.
- R8: If the data line still reads low after the ninth pulse, the run ends with failed = 1 and no STOP is attempted (sda_oe_o stays 0).
- R9: When the clock line is released but reads low (stretching), the block waits without counting the high phase. If it stays low for STRETCH_TICKS ticks, the run ends with failed = 1.
- R10: busy rises in the cycle after start is taken and stays high until completion. done is a one-cycle pulse in the first cycle with busy low. failed is cleared when a start is taken and otherwise holds its value until the next start.
- R11: A start request while busy is 1 is ignored and does not change the pulse count of the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a recovery run (taken when idle) |
| tick_i | input | 1 | One-cycle timing tick from the prescaler |
| scl_in_i | input | 1 | Clock line level as read from the pad |
| sda_in_i | input | 1 | Data line level as read from the pad |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Recovery run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| failed_o | output | 1 | Last run could not free the bus |

## Verification
On every cycle the assertions check the following:
- both lines are released while idle;
- the data line is only pulled while the clock line is released;
- no run exceeds nine clock pulses;
- done is a single-cycle pulse at the busy falling edge;
- failed never changes while the block is idle without a start.

Only the bench scenarios can show the rest, because each needs a target model that responds to the clock:
- the exact pulse count for each release point, including zero and nine;
- the STOP edge appearing or being withheld;
- the length of the low phases;
- waiting through clock stretching and timing out of it;
- a second start being ignored.

// File: rtl/unjam_pkg.sv
package unjam_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PROBE    = 3'd1,
        ST_CLK_LOW  = 3'd2,
        ST_CLK_RISE = 3'd3,
        ST_CLK_HIGH = 3'd4,
        ST_STOP_DRV = 3'd5,
        ST_STOP_REL = 3'd6
    } unjam_state_e;

    typedef struct packed {
        logic pull_scl;
        logic pull_sda;
    } drive_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= '1;
                else     stg_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= '1;
                else     stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/unjam_timer.sv
module unjam_timer #(
    parameter int unsigned LIMIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expire = tick && !load && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || load)          cnt_q <= '0;
        else if (tick && !expire) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bus_unjam.sv
module bus_unjam
    import unjam_pkg::*;
#(
    parameter int unsigned HALF_TICKS    = 5,
    parameter int unsigned MAX_PULSES    = 9,
    parameter int unsigned STRETCH_TICKS = 1000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic tick_i,
    input  logic scl_in_i,
    input  logic sda_in_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic failed_o
);
    localparam int unsigned PW = cnt_width(MAX_PULSES);
    localparam logic [PW-1:0] LAST_PULSE = PW'(MAX_PULSES - 1);

    unjam_state_e state_q, state_n;
    logic [PW-1:0] pulse_q, pulse_n;
    logic          load_q;
    logic          done_q, failed_q;
    logic          fin, fin_fail;
    logic          take_start;
    logic          ph_exp, st_exp;
    lines_t        raw, synced;
    drive_t        drv;

    // two-flop synchronizer on both lines
    assign raw.scl = scl_in_i;
    assign raw.sda = sda_in_i;

    unjam_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw),
        .dout (synced)
    );

    // phase timer restarts on every state entry
    unjam_timer #(.LIMIT(HALF_TICKS)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .load   (load_q),
        .tick   (tick_i),
        .expire (ph_exp)
    );

    // stretch guard runs only while waiting for the clock to rise
    unjam_timer #(.LIMIT(STRETCH_TICKS)) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .load   (state_q != ST_CLK_RISE),
        .tick   (tick_i),
        .expire (st_exp)
    );

    assign take_start = (state_q == ST_IDLE) && start_i;

    always_comb begin
        state_n  = state_q;
        pulse_n  = pulse_q;
        fin      = 1'b0;
        fin_fail = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_n = ST_PROBE;
            end
            ST_PROBE: begin
                pulse_n = '0;
                state_n = synced.sda ? ST_STOP_DRV : ST_CLK_LOW;
            end
            ST_CLK_LOW: begin
                if (ph_exp) state_n = ST_CLK_RISE;
            end
            ST_CLK_RISE: begin
                if (synced.scl) begin
                    state_n = ST_CLK_HIGH;
                end else if (st_exp) begin
                    state_n  = ST_IDLE;
                    fin      = 1'b1;
                    fin_fail = 1'b1;
                end
            end
            ST_CLK_HIGH: begin
                if (ph_exp) begin
                    if (synced.sda) begin
                        state_n = ST_STOP_DRV;
                    end else if (pulse_q == LAST_PULSE) begin
                        state_n  = ST_IDLE;
                        fin      = 1'b1;
                        fin_fail = 1'b1;
                    end else begin
                        pulse_n = pulse_q + 1'b1;
                        state_n = ST_CLK_LOW;
                    end
                end
            end
            ST_STOP_DRV: begin
                if (ph_exp) state_n = ST_STOP_REL;
            end
            ST_STOP_REL: begin
                if (ph_exp) begin
                    state_n = ST_IDLE;
                    fin     = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pulse_q  <= '0;
            load_q   <= 1'b1;
            done_q   <= 1'b0;
            failed_q <= 1'b0;
        end else begin
            state_q <= state_n;
            pulse_q <= pulse_n;
            load_q  <= (state_n != state_q);
            done_q  <= fin;
            if (take_start)  failed_q <= 1'b0;
            else if (fin)    failed_q <= fin_fail;
        end
    end

    // open-drain: only ever pull low, release otherwise
    always_comb begin
        drv.pull_scl = (state_q == ST_CLK_LOW);
        drv.pull_sda = (state_q == ST_STOP_DRV);
    end

    assign scl_oe_o = drv.pull_scl;
    assign sda_oe_o = drv.pull_sda;
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign failed_o = failed_q;
endmodule

// File: rtl/bus_unjam_chk.sv
module bus_unjam_chk #(
    parameter int unsigned MAX_PULSES = 9
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic failed_o
);
    logic [7:0] rises_q;
    logic       scl_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rises_q    <= '0;
            scl_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_oe_o;
            if (!busy_o)                         rises_q <= '0;
            else if (scl_oe_o && !scl_prev_q && rises_q != 8'hFF) rises_q <= rises_q + 1'b1;
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_oe_o && !sda_oe_o)); // R2

    AST_SDA_PULL_SCL_FREE: assert property (@(posedge clk) disable iff (rst)
        sda_oe_o |-> !scl_oe_o); // R6

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (rises_q <= 8'(MAX_PULSES))); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R10

    AST_FAILED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(failed_o)); // R10
endmodule

bind bus_unjam bus_unjam_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .failed_o (failed_o)
);

// File: tb/sim_bus_unjam.sv
`timescale 1ns/1ps
module sim_bus_unjam;
    localparam int HALF = 3;
    localparam int MAXP = 9;
    localparam int STRT = 20;
    localparam int TP   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic tick_i = 1'b0;
    logic scl_oe_o, sda_oe_o, busy_o, done_o, failed_o;
    logic hold_scl = 1'b0;
    logic tgt_low = 1'b0;
    logic tgt_clear = 1'b0;
    int   tgt_release = 0;
    int   tgt_edges = 0;
    logic scl_line, sda_line, scl_prev_p;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit wd = 1'b0;

    always #4 clk = ~clk;

    assign scl_line = !(scl_oe_o || hold_scl);
    assign sda_line = !(sda_oe_o || tgt_low);

    bus_unjam #(.HALF_TICKS(HALF), .MAX_PULSES(MAXP), .STRETCH_TICKS(STRT), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
        .scl_in_i(scl_line), .sda_in_i(sda_line),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
        .busy_o(busy_o), .done_o(done_o), .failed_o(failed_o));

    // prescaler tick every TP cycles
    int div = 0;
    always @(posedge clk) begin
        div    <= (div == TP - 1) ? 0 : div + 1;
        tick_i <= (div == TP - 1);
    end

    // target model: holds data low until it has seen tgt_release clock rises
    always @(posedge clk) begin
        scl_prev_p <= scl_line;
        if (tgt_clear) begin
            tgt_edges <= 0;
            tgt_low   <= (tgt_release != 0);
        end else if (scl_line && !scl_prev_p) begin
            tgt_edges <= tgt_edges + 1;
            if (tgt_edges + 1 >= tgt_release) tgt_low <= 1'b0;
        end
    end

    // bus monitor
    logic mon_clear = 1'b0;
    int   pulses, low_len, low_min, low_max;
    bit   sda_seen, stop_seen;
    logic p_scl_oe, p_sda_line, p_scl_line;
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) wd <= 1'b1;
        if (mon_clear) begin
            pulses <= 0; low_len <= 0; low_min <= 1 << 20; low_max <= 0;
            sda_seen <= 0; stop_seen <= 0;
        end else begin
            if (scl_oe_o && !p_scl_oe) pulses <= pulses + 1;
            if (scl_oe_o) low_len <= low_len + 1;
            if (!scl_oe_o && p_scl_oe) begin
                if (low_len < low_min) low_min <= low_len;
                if (low_len > low_max) low_max <= low_len;
                low_len <= 0;
            end
            if (sda_oe_o) sda_seen <= 1'b1;
            if (sda_line && !p_sda_line && scl_line && p_scl_line) stop_seen <= 1'b1;
        end
        p_scl_oe   <= scl_oe_o;
        p_sda_line <= sda_line;
        p_scl_line <= scl_line;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one recovery run; hold: 0 none, >0 cycles of clock stretch, -1 forever
    task automatic run_case(input string tag, input int rel, input int hold,
                            input int exp_pulses, input bit exp_fail, input bit kick);
        @(negedge clk);
        tgt_release = rel; tgt_clear = 1'b1; mon_clear = 1'b1;
        hold_scl = (hold != 0);
        @(negedge clk);
        @(negedge clk);
        tgt_clear = 1'b0; mon_clear = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, {"R10 busy after start ", tag}, busy_o, 1);
        chk(failed_o == 1'b0, {"R10 failed cleared by start ", tag}, failed_o, 0);
        if (kick) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            hold_scl = 1'b0;
        end
        while (!done_o && !wd) @(negedge clk);
        chk(done_o == 1'b1, {"R10 done seen ", tag}, done_o, 1);
        chk(busy_o == 1'b0, {"R10 busy low with done ", tag}, busy_o, 0);
        chk(failed_o == exp_fail, {"R8 R9 failed flag ", tag}, failed_o, exp_fail);
        chk(pulses == exp_pulses, {"R4 R5 pulse count ", tag}, pulses, exp_pulses);
        chk(sda_seen == !exp_fail, {"R6 R8 data pull ", tag}, sda_seen, !exp_fail);
        chk(stop_seen == !exp_fail, {"R6 stop edge ", tag}, stop_seen, !exp_fail);
        chk(!scl_oe_o && !sda_oe_o, {"R2 released at end ", tag}, scl_oe_o + sda_oe_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, {"R10 done one cycle ", tag}, done_o, 0);
        hold_scl = 1'b0;
    endtask

    task automatic t_reset();
        chk(!scl_oe_o && !sda_oe_o, "R1 enables in reset", scl_oe_o + sda_oe_o, 0);
        chk(!busy_o && !done_o && !failed_o, "R1 flags in reset", busy_o + done_o + failed_o, 0);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!scl_oe_o && !sda_oe_o && !busy_o, "R2 idle after reset", scl_oe_o + sda_oe_o + busy_o, 0);
    endtask

    task automatic t_clean_bus();  // R7
        run_case("R7 clean", 0, 0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_partial();    // R5, R3
        run_case("R5 partial", 3, 0, 3, 1'b0, 1'b0);
        chk(low_min >= (HALF - 1) * TP + 1, "R3 low phase min", low_min, (HALF - 1) * TP + 1);
        chk(low_max <= HALF * TP + 1, "R3 low phase max", low_max, HALF * TP + 1);
    endtask

    task automatic t_boundary();   // R4
        run_case("R4 nine", 9, 0, 9, 1'b0, 1'b0);
    endtask

    task automatic t_stuck();      // R8, R10
        run_case("R8 stuck", 99, 0, 9, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        chk(failed_o == 1'b1, "R10 failed holds idle", failed_o, 1);
    endtask

    task automatic t_restart();    // R11
        run_case("R11 restart", 2, 0, 2, 1'b0, 1'b1);
    endtask

    task automatic t_stretch();    // R9
        run_case("R9 stretch", 3, 60, 3, 1'b0, 1'b0);
    endtask

    task automatic t_timeout();    // R9
        run_case("R9 timeout", 5, -1, 1, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_clean_bus();
        t_partial();
        t_boundary();
        t_stuck();
        t_restart();
        t_stretch();
        t_timeout();
        if (wd) chk(1'b0, "watchdog", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule